// File: doc/BRIEF.md
# Scaled-index effective address generator

This block forms the 64-bit address of a memory operand from its parts: an optional base register value, an optional index register value shifted left by a 2-bit scale code, and a sign-extended displacement of one, two or four bytes. It also serves an address-only operation that returns the same value but requests no memory access. That operation touches no condition flags, and the block has none to touch. Encodings that the addressing form forbids raise an illegal flag. One forbidden encoding is the stack-pointer register (number 4) used as index. The other is an eight-byte displacement.

Operands enter on a valid/ready request port. The result leaves on a valid/ready response port, one register stage later. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the response holds unchanged and no new request is taken. Register file reads and instruction decoding happen upstream.

Top module: `ea_gen`

## Requirements
- R1: For a legal request, `out_addr` equals base term plus index term plus extended displacement, wrapped modulo 2^64.
- R2: Scale code s (0..3) multiplies the index value by 2^s, that is by 1, 2, 4 or 8.
- R3: Size code 0 takes `disp_val[7:0]`, code 1 takes `disp_val[15:0]` and code 2 takes `disp_val[31:0]`. Each is sign-extended to 64 bits, and the higher input bits have no effect.
- R4: Size code 3 (an eight-byte displacement) is illegal and sets `out_illegal`.
- R5: With `base_en` low, the base term is zero whatever `base_val` holds.
- R6: With `idx_en` low, the index term is zero whatever the scale. `idx_num` is then ignored, and number 4 raises no illegal flag.
- R7: With `idx_en` high and `idx_num` equal to 4, `out_illegal` is set. Every other index number is legal.
- R8: An illegal request returns `out_addr` = 0 and `out_mem` = 0.
- R9: `out_mem` is 1 for a legal request with `addr_only` low. With `addr_only` high it is 0, and the address is still returned.
- R10: A request taken at a rising edge is presented with `out_valid` high after that edge. `in_ready` = !out_valid || out_ready. While `out_ready` is low, the response stays stable and no new request is taken.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| base_en | input | 1 | Base term present |
| base_val | input | 64 | Base register value |
| idx_en | input | 1 | Index term present |
| idx_num | input | 4 | Index register number |
| idx_val | input | 64 | Index register value |
| scale_code | input | 2 | Index shift amount |
| disp_val | input | 32 | Displacement bits |
| disp_size | input | 2 | Displacement size code |
| addr_only | input | 1 | Address-only operation, no memory access |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Response consumer ready |
| out_addr | output | 64 | Effective address |
| out_illegal | output | 1 | Forbidden encoding |
| out_mem | output | 1 | Memory access requested |

## Verification
The block keeps state only in its single output stage. A wrong term selection, a wrong shift or a wrong extension therefore appears on `out_addr` in the very cycle after the request is taken. Each term is checked in isolation with boundary values: a sign bit set in the smallest size, garbage in the upper displacement bits, and a sum that wraps. A fault in the holding logic shows up as a response that changes, or is overwritten, while `out_ready` is low. It also shows as a second request taken during the stall. Both are visible at the first edge of the stall.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EA_ADDR_W = 64;
  localparam int EA_DISP_W = 32;
  localparam int EA_RNUM_W = 4;

  typedef enum logic [1:0] {
    DSZ_ONE  = 2'd0,
    DSZ_TWO  = 2'd1,
    DSZ_FOUR = 2'd2,
    DSZ_WIDE = 2'd3
  } disp_size_e;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
  import ea_pkg::*;
#(
  parameter int ADDR_W = EA_ADDR_W,
  parameter int DISP_W = EA_DISP_W
) (
  input  logic [DISP_W-1:0] disp_val,
  input  logic [1:0]        disp_size,
  output logic [ADDR_W-1:0] disp_ext
);
  localparam int HALF_W = DISP_W / 2;
  localparam int BYTE_W = DISP_W / 4;

  always_comb begin
    case (disp_size)
      DSZ_ONE:  disp_ext = {{(ADDR_W-BYTE_W){disp_val[BYTE_W-1]}}, disp_val[BYTE_W-1:0]};
      DSZ_TWO:  disp_ext = {{(ADDR_W-HALF_W){disp_val[HALF_W-1]}}, disp_val[HALF_W-1:0]};
      DSZ_FOUR: disp_ext = {{(ADDR_W-DISP_W){disp_val[DISP_W-1]}}, disp_val};
      default:  disp_ext = '0;
    endcase
  end
endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale
  import ea_pkg::*;
#(
  parameter int ADDR_W = EA_ADDR_W
) (
  input  logic              idx_en,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [1:0]        scale_code,
  output logic [ADDR_W-1:0] idx_term
);
  always_comb begin
    idx_term = idx_en ? (idx_val << scale_code) : '0;
  end
endmodule

// File: rtl/ea_legal_check.sv
module ea_legal_check
  import ea_pkg::*;
#(
  parameter int RNUM_W     = EA_RNUM_W,
  parameter int FORBID_IDX = 4
) (
  input  logic              idx_en,
  input  logic [RNUM_W-1:0] idx_num,
  input  logic [1:0]        disp_size,
  output logic              illegal
);
  localparam logic [RNUM_W-1:0] FORBID_NUM = RNUM_W'(FORBID_IDX);

  always_comb begin
    illegal = (idx_en && (idx_num == FORBID_NUM)) || (disp_size == DSZ_WIDE);
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W     = EA_ADDR_W,
  parameter int DISP_W     = EA_DISP_W,
  parameter int RNUM_W     = EA_RNUM_W,
  parameter int FORBID_IDX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              base_en,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              idx_en,
  input  logic [RNUM_W-1:0] idx_num,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [1:0]        scale_code,
  input  logic [DISP_W-1:0] disp_val,
  input  logic [1:0]        disp_size,
  input  logic              addr_only,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_illegal,
  output logic              out_mem
);
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] sum;
  logic              illegal;
  logic              take;

  ea_disp_ext #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_disp (
    .disp_val  (disp_val),
    .disp_size (disp_size),
    .disp_ext  (disp_ext)
  );

  ea_index_scale #(.ADDR_W(ADDR_W)) u_scale (
    .idx_en     (idx_en),
    .idx_val    (idx_val),
    .scale_code (scale_code),
    .idx_term   (idx_term)
  );

  ea_legal_check #(.RNUM_W(RNUM_W), .FORBID_IDX(FORBID_IDX)) u_legal (
    .idx_en    (idx_en),
    .idx_num   (idx_num),
    .disp_size (disp_size),
    .illegal   (illegal)
  );

  assign base_term = base_en ? base_val : '0;
  assign sum       = base_term + idx_term + disp_ext;
  assign in_ready  = !out_valid || out_ready;
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_illegal <= 1'b0;
      out_mem     <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_addr    <= illegal ? '0 : sum;
      out_illegal <= illegal;
      out_mem     <= !illegal && !addr_only;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable(out_illegal) && $stable(out_mem)));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_forbid_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx_en && (idx_num == RNUM_W'(FORBID_IDX))) |=> out_illegal);

  p_wide_disp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (disp_size == DSZ_WIDE)) |=> (out_illegal && (out_addr == '0)));

  p_addr_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && addr_only) |=> !out_mem);

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_mem && (out_addr == '0)));
endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        base_en = 1'b0;
  logic [63:0] base_val = '0;
  logic        idx_en = 1'b0;
  logic [3:0]  idx_num = '0;
  logic [63:0] idx_val = '0;
  logic [1:0]  scale_code = '0;
  logic [31:0] disp_val = '0;
  logic [1:0]  disp_size = '0;
  logic        addr_only = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_addr;
  logic        out_illegal;
  logic        out_mem;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_en(base_en), .base_val(base_val), .idx_en(idx_en), .idx_num(idx_num),
    .idx_val(idx_val), .scale_code(scale_code), .disp_val(disp_val),
    .disp_size(disp_size), .addr_only(addr_only), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_illegal(out_illegal),
    .out_mem(out_mem)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic be, input logic [63:0] b, input logic ie,
                       input logic [3:0] inum, input logic [63:0] iv,
                       input logic [1:0] sc, input logic [31:0] d,
                       input logic [1:0] dsz, input logic ao);
    base_en = be; base_val = b; idx_en = ie; idx_num = inum; idx_val = iv;
    scale_code = sc; disp_val = d; disp_size = dsz; addr_only = ao;
  endtask

  // one request through with out_ready high, checked at the next negedge
  task automatic run_one(input string tag, input logic [63:0] ea,
                         input logic ill, input logic mem);
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " addr"}, out_addr, ea);
    chk({tag, " illegal"}, {63'd0, out_illegal}, {63'd0, ill});
    chk({tag, " mem"}, {63'd0, out_mem}, {63'd0, mem});
  endtask

  task automatic t_reset;
    chk("R11 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R11 reset ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_sum;
    @(negedge clk); drive(1, 64'hf000, 1, 4'd1, 64'h100, 2'd0, 32'd0, 2'd0, 0);
    run_one("R1 base+index", 64'hf100, 0, 1);
    @(negedge clk); drive(1, 64'hf000, 1, 4'd1, 64'h100, 2'd2, 32'd0, 2'd0, 0);
    run_one("R2 scale x4", 64'hf400, 0, 1);
    @(negedge clk); drive(1, 64'h10, 1, 4'd9, 64'h3, 2'd3, 32'd0, 2'd0, 0);
    run_one("R2 scale x8", 64'h28, 0, 1);
    @(negedge clk); drive(1, 64'hffff_ffff_ffff_ffff, 0, 4'd0, 64'd0, 2'd0, 32'd1, 2'd0, 0);
    run_one("R1 wrap", 64'd0, 0, 1);
  endtask

  task automatic t_disp;
    @(negedge clk); drive(1, 64'h1000, 0, 4'd0, 64'd0, 2'd0, 32'hABCD_0080, 2'd0, 0);
    run_one("R3 byte sign", 64'hf80, 0, 1);
    @(negedge clk); drive(1, 64'h1000, 0, 4'd0, 64'd0, 2'd0, 32'hABCD_0012, 2'd0, 0);
    run_one("R3 byte upper ignored", 64'h1012, 0, 1);
    @(negedge clk); drive(1, 64'h1000, 0, 4'd0, 64'd0, 2'd0, 32'h7777_8000, 2'd1, 0);
    run_one("R3 two-byte sign", 64'hffff_ffff_ffff_9000, 0, 1);
    @(negedge clk); drive(1, 64'h1000, 0, 4'd0, 64'd0, 2'd0, 32'hffff_fff0, 2'd2, 0);
    run_one("R3 four-byte neg", 64'hff0, 0, 1);
    @(negedge clk); drive(1, 64'h1000, 1, 4'd2, 64'h8, 2'd0, 32'h10, 2'd3, 0);
    run_one("R4 wide disp", 64'd0, 1, 0);
  endtask

  task automatic t_optional;
    @(negedge clk); drive(0, 64'hdead_beef, 1, 4'd3, 64'hf000, 2'd1, 32'h80, 2'd1, 0);
    run_one("R5 no base", 64'h1e080, 0, 1);
    @(negedge clk); drive(1, 64'h500, 0, 4'd4, 64'hffff, 2'd3, 32'h4, 2'd0, 0);
    run_one("R6 no index", 64'h504, 0, 1);
  endtask

  task automatic t_forbid;
    @(negedge clk); drive(1, 64'h500, 1, 4'd4, 64'h1, 2'd0, 32'h0, 2'd0, 0);
    run_one("R7 index 4", 64'd0, 1, 0);
    @(negedge clk); drive(1, 64'h500, 1, 4'd5, 64'h1, 2'd0, 32'h0, 2'd0, 0);
    run_one("R7 index 5 legal", 64'h501, 0, 1);
    @(negedge clk); drive(1, 64'h500, 1, 4'd4, 64'h1, 2'd0, 32'h0, 2'd0, 1);
    run_one("R8 illegal addr-only", 64'd0, 1, 0);
  endtask

  task automatic t_addr_only;
    @(negedge clk); drive(1, 64'h2000, 1, 4'd6, 64'h10, 2'd1, 32'h4, 2'd0, 1);
    run_one("R9 addr-only", 64'h2024, 0, 0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    drive(1, 64'h100, 0, 4'd0, 64'd0, 2'd0, 32'h1, 2'd0, 0);
    in_valid = 1'b1;
    @(posedge clk);
    #1 drive(1, 64'h900, 0, 4'd0, 64'd0, 2'd0, 32'h2, 2'd0, 0);
    @(negedge clk);
    chk("R10 stall valid", {63'd0, out_valid}, 64'd1);
    chk("R10 stall ready low", {63'd0, in_ready}, 64'd0);
    chk("R10 first held", out_addr, 64'h101);
    @(negedge clk);
    @(negedge clk);
    chk("R10 held after two edges", out_addr, 64'h101);
    out_ready = 1'b1;
    #1 chk("R10 ready follows out_ready", {63'd0, in_ready}, 64'd1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R10 second taken", out_addr, 64'h902);
    chk("R10 second valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R10 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2;
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_sum;
    t_disp;
    t_optional;
    t_forbid;
    t_addr_only;
    t_stall;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule